// File: doc/BRIEF.md
# Cross-Coupled Parallel Port Mailbox

This block joins two processor buses, a host bus and a disk-unit bus, through a pair of byte latches and a pair of control bytes. It behaves like two parallel port chips wired back to back. A byte that one side writes appears as input on the other side. The upper four handshake bits that one side writes appear in the lower four bits that the other side reads.

The host sees three byte registers at offsets 0, 1 and 2. The disk side sees three port registers (A, B and C) and, at offset 3, a control port.

Reading the control port fires a single-clock terminal-count strobe for a floppy controller and returns all ones. Writing the control port sets the drive motor line. Every read is combinational from registered state, so a value written on one side can be read on the other side one clock later.

Top module: `xlink_mailbox`

## Requirements
- R1: After reset every latch is zero. Every mapped data read returns 0x00, except a disk read of offset 3, which returns 0xFF. `tc_pulse` is low, and every bit of `motor_n` is 1 (motor off).
- R2: A host write to offset 0 stores the byte. From the next clock on, a disk read of offset 0 (port A) returns it.
- R3: A disk write to offset 1 (port B) stores the byte. From the next clock on, a host read of offset 1 returns it, and so does a disk read of offset 1.
- R4: A host write to offset 2 stores a control byte. A disk read of offset 2 (port C) returns that byte shifted right by four: the host's bits 7:4 appear in bits 3:0, and bits 7:4 read as zero.
- R5: A disk write to offset 2 stores a control byte. A host read of offset 2 returns that byte shifted right by four, in the same way as R4.
- R6: A disk read of offset 3 returns 0xFF. In the cycle after the first clock edge that samples this read, `tc_pulse` is high for exactly one clock. Holding the read for more cycles gives no further pulse. A new read after the strobe drops gives a new pulse.
- R7: A disk write to offset 3 sets every bit of `motor_n` to the inverse of data bit 0 at the next clock. The other data bits are ignored. The value holds until the next such write.
- R8: A host read of offset 0 and a host read of offset 3 both return 0x00. A disk write to offset 0 is ignored: afterwards port A still returns the host's byte, and host offset 1 still returns the port B byte.
- R9: Reads never change a latch. Writes on one side never change a latch that the other side owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs | input | 1 | Host access select |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0 when not reading) |
| disk_cs | input | 1 | Disk-side access select |
| disk_addr | input | 2 | Disk-side offset (3 = control port) |
| disk_wr | input | 1 | Disk-side write strobe |
| disk_rd | input | 1 | Disk-side read strobe |
| disk_wdata | input | 8 | Disk-side write data |
| disk_rdata | output | 8 | Disk-side read data (0 when not reading) |
| tc_pulse | output | 1 | Terminal-count strobe, one clock long |
| motor_n | output | 2 | Motor line per drive, active low |

## Verification
The hardest case to reach is a control-port read that is held for several cycles. A single-cycle read cannot tell an edge-detected strobe from a level-following one. So the stimulus holds the read for three clocks and checks the strobe in each of them. It then drops the read, raises it again and expects a second pulse.

The nibble crossing is checked with control bytes whose upper and lower halves differ. A design that shifts the wrong way, or that leaks the lower half, then reads back a wrong value.

// File: rtl/xlink_pkg.sv
// Package: shared offsets and widths for the cross-coupled mailbox.
// Assumes both buses use the same 2-bit offset space.
package xlink_pkg;
    localparam int unsigned DATA_W = 8;

    // Host side offsets
    localparam logic [1:0] HOST_OFF_TODISK = 2'd0;
    localparam logic [1:0] HOST_OFF_FROMDISK = 2'd1;
    localparam logic [1:0] HOST_OFF_CTRL = 2'd2;

    // Disk side offsets
    localparam logic [1:0] DISK_OFF_PA = 2'd0;
    localparam logic [1:0] DISK_OFF_PB = 2'd1;
    localparam logic [1:0] DISK_OFF_PC = 2'd2;
    localparam logic [1:0] DISK_OFF_CTL = 2'd3;
endpackage

// File: rtl/xlink_host_regs.sv
// Host-side register file: owns the outbound data byte and the host control
// byte, and decodes host reads of the peer latches.
// Assumes synchronous active-low reset and single-cycle write strobes.
module xlink_host_regs
    import xlink_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] peer_byte,
    input  logic [DW-1:0] peer_ctl,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] out_byte,
    output logic [DW-1:0] out_ctl
);
    localparam int unsigned NIB = DW / 2;

    logic wr_byte, wr_ctl;
    assign wr_byte = cs && wr && (addr == HOST_OFF_TODISK);
    assign wr_ctl  = cs && wr && (addr == HOST_OFF_CTRL);

    // Capture host writes into the two host-owned latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_ctl  <= '0;
        end else begin
            if (wr_byte) out_byte <= wdata;
            if (wr_ctl)  out_ctl  <= wdata;
        end
    end

    // Decode a host read from the peer latches.
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (addr)
                HOST_OFF_FROMDISK: rdata = peer_byte;
                HOST_OFF_CTRL:     rdata = peer_ctl >> NIB;
                default:           rdata = '0;
            endcase
        end
    end

    a_r9_host_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_byte |=> $stable(out_byte));
    a_r9_host_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(out_ctl));
endmodule

// File: rtl/xlink_disk_regs.sv
// Disk-side port registers: port A reads the host byte, port B is the
// outbound latch, port C crosses control nibbles, offset 3 reads all ones.
// Assumes the control-port strobes themselves are handled elsewhere.
module xlink_disk_regs
    import xlink_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] peer_byte,
    input  logic [DW-1:0] peer_ctl,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] out_byte,
    output logic [DW-1:0] out_ctl
);
    localparam int unsigned NIB = DW / 2;

    logic wr_pb, wr_pc;
    assign wr_pb = cs && wr && (addr == DISK_OFF_PB);
    assign wr_pc = cs && wr && (addr == DISK_OFF_PC);

    // Capture disk writes to port B and port C.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_ctl  <= '0;
        end else begin
            if (wr_pb) out_byte <= wdata;
            if (wr_pc) out_ctl  <= wdata;
        end
    end

    // Decode a disk read of the port set or the control port.
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (addr)
                DISK_OFF_PA:  rdata = peer_byte;
                DISK_OFF_PB:  rdata = out_byte;
                DISK_OFF_PC:  rdata = peer_ctl >> NIB;
                default:      rdata = '1;
            endcase
        end
    end

    a_r9_disk_pb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pb |=> $stable(out_byte));
    a_r9_disk_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pc |=> $stable(out_ctl));
endmodule

// File: rtl/xlink_ctl_port.sv
// Control port: an edge-detected terminal-count strobe on read and a motor
// latch on write, fanned out inverted to every drive.
// Assumes rd_stb and wr_stb are already decoded for the control offset.
module xlink_ctl_port #(
    parameter int unsigned NUM_DRIVES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_stb,
    input  logic                  wr_stb,
    input  logic                  wbit,
    output logic                  tc,
    output logic [NUM_DRIVES-1:0] motor_n
);
    logic rd_prev;
    logic run_q;

    // Fire tc for one clock on the rising edge of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            tc      <= 1'b0;
        end else begin
            rd_prev <= rd_stb;
            tc      <= rd_stb && !rd_prev;
        end
    end

    // Latch the motor request bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else if (wr_stb) run_q <= wbit;
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        assign motor_n[d] = ~run_q;
    end

    a_r6_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    a_r6_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(rd_stb));
    a_r7_motor_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (motor_n == {NUM_DRIVES{~$past(wbit)}}));
    a_r7_motor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(motor_n));
endmodule

// File: rtl/xlink_mailbox.sv
// Top: cross-couples the host register file and the disk port set, and
// attaches the control port. Each side's byte latch feeds the other side,
// and each side's control byte feeds the other side's nibble read.
// Assumes both buses share one clock.
module xlink_mailbox
    import xlink_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NUM_DRIVES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_cs,
    input  logic [1:0]            host_addr,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [DW-1:0]         host_wdata,
    output logic [DW-1:0]         host_rdata,
    input  logic                  disk_cs,
    input  logic [1:0]            disk_addr,
    input  logic                  disk_wr,
    input  logic                  disk_rd,
    input  logic [DW-1:0]         disk_wdata,
    output logic [DW-1:0]         disk_rdata,
    output logic                  tc_pulse,
    output logic [NUM_DRIVES-1:0] motor_n
);
    logic [DW-1:0] h_byte, h_ctl, d_byte, d_ctl;
    logic ctl_rd, ctl_wr;

    assign ctl_rd = disk_cs && disk_rd && (disk_addr == DISK_OFF_CTL);
    assign ctl_wr = disk_cs && disk_wr && (disk_addr == DISK_OFF_CTL);

    xlink_host_regs #(.DW(DW)) host_i (
        .clk(clk), .rst_n(rst_n), .cs(host_cs), .addr(host_addr),
        .wr(host_wr), .rd(host_rd), .wdata(host_wdata),
        .peer_byte(d_byte), .peer_ctl(d_ctl),
        .rdata(host_rdata), .out_byte(h_byte), .out_ctl(h_ctl)
    );

    xlink_disk_regs #(.DW(DW)) disk_i (
        .clk(clk), .rst_n(rst_n), .cs(disk_cs), .addr(disk_addr),
        .wr(disk_wr), .rd(disk_rd), .wdata(disk_wdata),
        .peer_byte(h_byte), .peer_ctl(h_ctl),
        .rdata(disk_rdata), .out_byte(d_byte), .out_ctl(d_ctl)
    );

    xlink_ctl_port #(.NUM_DRIVES(NUM_DRIVES)) ctl_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(ctl_rd), .wr_stb(ctl_wr),
        .wbit(disk_wdata[0]), .tc(tc_pulse), .motor_n(motor_n)
    );

    a_r2_host_to_disk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && host_addr == HOST_OFF_TODISK) |=> (h_byte == $past(host_wdata)));
    a_r3_disk_to_host: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_cs && disk_wr && disk_addr == DISK_OFF_PB) |=> (d_byte == $past(disk_wdata)));
endmodule

// File: tb/xlink_mailbox_tb.sv
module xlink_mailbox_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int NV = 20;
    // vector: {req[3:0], op[1:0], addr[1:0], data[7:0], exp[7:0]}
    // op 0 host write, 1 host read, 2 disk write, 3 disk read
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 2'd0, 2'd0, 8'hA5, 8'h00},  // R2 host byte out
        {4'd2, 2'd3, 2'd0, 8'h00, 8'hA5},  // R2 port A sees it
        {4'd3, 2'd2, 2'd1, 8'h3C, 8'h00},  // R3 port B write
        {4'd3, 2'd1, 2'd1, 8'h00, 8'h3C},  // R3 host offset 1
        {4'd3, 2'd3, 2'd1, 8'h00, 8'h3C},  // R3 port B readback
        {4'd4, 2'd0, 2'd2, 8'hF0, 8'h00},  // R4 host ctl
        {4'd4, 2'd3, 2'd2, 8'h00, 8'h0F},  // R4 port C
        {4'd4, 2'd0, 2'd2, 8'h7E, 8'h00},  // R4
        {4'd4, 2'd3, 2'd2, 8'h00, 8'h07},  // R4 low half dropped
        {4'd5, 2'd2, 2'd2, 8'h9B, 8'h00},  // R5 disk ctl
        {4'd5, 2'd1, 2'd2, 8'h00, 8'h09},  // R5 host offset 2
        {4'd5, 2'd2, 2'd2, 8'h45, 8'h00},  // R5
        {4'd5, 2'd1, 2'd2, 8'h00, 8'h04},  // R5
        {4'd9, 2'd0, 2'd0, 8'h11, 8'h00},  // R9 new host byte
        {4'd9, 2'd3, 2'd0, 8'h00, 8'h11},  // R9
        {4'd9, 2'd1, 2'd1, 8'h00, 8'h3C},  // R9 port B untouched
        {4'd8, 2'd1, 2'd0, 8'h00, 8'h00},  // R8 host offset 0 reads 0
        {4'd8, 2'd1, 2'd3, 8'h00, 8'h00},  // R8 host offset 3 reads 0
        {4'd8, 2'd2, 2'd0, 8'hEE, 8'h00},  // R8 disk write to A ignored
        {4'd8, 2'd3, 2'd0, 8'h00, 8'h11}   // R8 port A unchanged
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs = 0, host_wr = 0, host_rd = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic disk_cs = 0, disk_wr = 0, disk_rd = 0;
    logic [1:0] disk_addr = 0;
    logic [7:0] disk_wdata = 0, disk_rdata;
    logic tc_pulse;
    logic [1:0] motor_n;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlink_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .disk_cs(disk_cs), .disk_addr(disk_addr), .disk_wr(disk_wr), .disk_rd(disk_rd),
        .disk_wdata(disk_wdata), .disk_rdata(disk_rdata),
        .tc_pulse(tc_pulse), .motor_n(motor_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_cs = 0; host_wr = 0;
    endtask
    task automatic dw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); disk_cs = 1; disk_wr = 1; disk_addr = a; disk_wdata = d;
        @(negedge clk); disk_cs = 0; disk_wr = 0;
    endtask
    task automatic hr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); host_cs = 1; host_rd = 1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk); host_cs = 0; host_rd = 0;
    endtask
    task automatic dr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); disk_cs = 1; disk_rd = 1; disk_addr = a;
        #1 v = disk_rdata;
        @(negedge clk); disk_cs = 0; disk_rd = 0;
    endtask

    task automatic reset_checks();
        logic [7:0] v;
        hr(2'd1, v); check("R1 host off1", v, 8'h00);
        hr(2'd2, v); check("R1 host off2", v, 8'h00);
        dr(2'd0, v); check("R1 port A", v, 8'h00);
        dr(2'd1, v); check("R1 port B", v, 8'h00);
        dr(2'd2, v); check("R1 port C", v, 8'h00);
        check("R1 motor off", {6'd0, motor_n}, 8'h03);
        check("R1 tc low", {7'd0, tc_pulse}, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq; logic [1:0] op, a; logic [7:0] d, e;
            {rq, op, a, d, e} = VEC[i];
            case (op)
                2'd0: hw(a, d);
                2'd2: dw(a, d);
                2'd1: begin hr(a, v); check($sformatf("R%0d vec %0d", rq, i), v, e); end
                default: begin dr(a, v); check($sformatf("R%0d vec %0d", rq, i), v, e); end
            endcase
        end

        // R6: held control read gives exactly one pulse, then re-arms
        @(negedge clk); disk_cs = 1; disk_rd = 1; disk_addr = 2'd3;
        #1 check("R6 read data", disk_rdata, 8'hFF);
        check("R6 tc before edge", {7'd0, tc_pulse}, 8'h00);
        @(posedge clk); #1 check("R6 tc pulse", {7'd0, tc_pulse}, 8'h01);
        @(posedge clk); #1 check("R6 tc drop", {7'd0, tc_pulse}, 8'h00);
        @(posedge clk); #1 check("R6 no retrigger", {7'd0, tc_pulse}, 8'h00);
        @(negedge clk); disk_cs = 0; disk_rd = 0;
        @(posedge clk); #1 check("R6 idle", {7'd0, tc_pulse}, 8'h00);
        @(negedge clk); disk_cs = 1; disk_rd = 1;
        @(posedge clk); #1 check("R6 re-arm", {7'd0, tc_pulse}, 8'h01);
        @(negedge clk); disk_cs = 0; disk_rd = 0;
        hr(2'd1, v); check("R9 tc read left port B", v, 8'h3C);

        // R7: motor from bit 0, inverted, other bits ignored
        dw(2'd3, 8'h01); check("R7 motor on", {6'd0, motor_n}, 8'h00);
        repeat (3) @(negedge clk);
        check("R7 motor held", {6'd0, motor_n}, 8'h00);
        dw(2'd3, 8'hFE); check("R7 upper bits ignored", {6'd0, motor_n}, 8'h03);
        dw(2'd3, 8'h03); check("R7 motor on again", {6'd0, motor_n}, 8'h00);
        hw(2'd2, 8'h01); check("R7 host write no effect", {6'd0, motor_n}, 8'h00);

        // R1: reset after activity clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        reset_checks();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule